// File: doc/BRIEF.md
# Vector lane permute unit

The unit rearranges the lanes of two 128-bit source vectors, A and B, into one 128-bit result. A 3-bit mode input selects one of six two-source lane orderings: transpose (even or odd pairs), unzip (even or odd lanes), or zip (low or high halves). A seventh mode is byte extract. In that mode the unit treats {B, A} as one 32-byte string and returns the 16-byte window that starts at a 4-bit byte offset.

A 2-bit size input picks the lane width used by the six lane modes. Byte extract always works in bytes, whatever the size input says. Lane 0 sits in the least significant bits of each vector.

By default the result passes through one output register, with a valid strobe that travels alongside it. The `REG_OUT` parameter removes that register and makes the path purely combinational.

Top module: `vperm_unit`

## Requirements
- R1: Mode 0 (transpose even) writes a[2i] to output lane 2i and b[2i] to output lane 2i+1. Mode 1 (transpose odd) writes a[2i+1] to lane 2i and b[2i+1] to lane 2i+1. With 32-bit lanes, A=[A,B,C,D] and B=[E,F,G,H], mode 0 gives [A,E,C,G] and mode 1 gives [B,F,D,H].
- R2: With N lanes, mode 2 (unzip even) fills output lanes 0..N/2-1 with the even lanes of A, then lanes N/2..N-1 with the even lanes of B. Mode 3 (unzip odd) does the same with the odd lanes. In the 32-bit example these modes give [A,C,E,G] and [B,D,F,H].
- R3: Mode 4 (zip low) writes a[i] to output lane 2i and b[i] to lane 2i+1, for i < N/2. Mode 5 (zip high) does the same with a[N/2+i] and b[N/2+i]. In the 32-bit example these modes give [A,E,B,F] and [C,G,D,H].
- R4: Mode 6 (extract) sets output byte j to byte (imm+j) of the 32-byte string {B,A}, where A is bytes 0..15. This holds for every offset from 0 to 15, including offsets that are not lane-aligned. Offsets 4, 8 and 12 give [B,C,D,E], [C,D,E,F] and [D,E,F,G] in the example.
- R5: Extract with offset 0 returns A unchanged.
- R6: The size input encodes 0 as 8-bit, 1 as 16-bit, 2 as 32-bit and 3 as 64-bit lanes. Modes 0 to 5 follow the selected lane width. Mode 6 ignores the size input.
- R7: Mode code 7 is undefined. For that input the result is all zeros, and illegal_o is high in the same cycle as valid_o.
- R8: With REG_OUT=1, the result and valid_o appear one clock after valid_i. valid_o is low while reset is applied and low one cycle after valid_i is low.
- R9: With REG_OUT=1, the result holds its last value while valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input operands valid |
| mode_i | input | 3 | Permute mode (0..6 defined, 7 illegal) |
| size_i | input | 2 | Lane size code for lane modes |
| imm_i | input | 4 | Byte offset for extract |
| src_a_i | input | 128 | Source vector A |
| src_b_i | input | 128 | Source vector B |
| valid_o | output | 1 | Result valid |
| result_o | output | 128 | Permuted result |
| illegal_o | output | 1 | Undefined mode flag, qualified by valid_o |

## Verification
The assertions check the output handshake on every cycle: the one-cycle valid latency, the held result when no operand arrives, the zero result and raised flag for the undefined mode, and the identity result of an extract at offset zero. The bench's scenarios are the only evidence for the lane orderings themselves. They cover all four lane widths and every unaligned extract offset, and they show that extract ignores the size input. The bench compares the outputs against a byte-level model, and also checks the literal character examples.

// File: rtl/vperm_pkg.sv
package vperm_pkg;
  typedef enum logic [2:0] {
    M_TRN_EVEN = 3'd0,
    M_TRN_ODD  = 3'd1,
    M_UZP_EVEN = 3'd2,
    M_UZP_ODD  = 3'd3,
    M_ZIP_LO   = 3'd4,
    M_ZIP_HI   = 3'd5,
    M_EXTRACT  = 3'd6,
    M_ILLEGAL  = 3'd7
  } vperm_mode_e;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned MIN_LANE_W = 8;
endpackage

// File: rtl/vperm_lanes.sv
module vperm_lanes
  import vperm_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned LANE_W = 32
) (
  input  vperm_mode_e      mode_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] res_o
);
  localparam int unsigned N = VEC_W / LANE_W;
  localparam int unsigned H = N / 2;

  logic [LANE_W-1:0] la [N];
  logic [LANE_W-1:0] lb [N];

  for (genvar k = 0; k < N; k++) begin : g_split
    assign la[k] = a_i[k*LANE_W +: LANE_W];
    assign lb[k] = b_i[k*LANE_W +: LANE_W];
  end

  for (genvar k = 0; k < N; k++) begin : g_out
    // per-lane source indices, all within 0..N-1
    localparam int unsigned PAIR = (k % 2 == 0) ? k : k - 1;
    localparam bit          ODDK = (k % 2 == 1);
    localparam int unsigned UE   = (k < H) ? 2 * k : 2 * (k - H);
    localparam bit          UHI  = (k >= H);
    localparam int unsigned ZL   = k / 2;
    localparam int unsigned ZH   = H + k / 2;

    always_comb begin
      unique case (mode_i)
        M_TRN_EVEN: res_o[k*LANE_W +: LANE_W] = ODDK ? lb[PAIR]     : la[PAIR];
        M_TRN_ODD:  res_o[k*LANE_W +: LANE_W] = ODDK ? lb[PAIR + 1] : la[PAIR + 1];
        M_UZP_EVEN: res_o[k*LANE_W +: LANE_W] = UHI  ? lb[UE]       : la[UE];
        M_UZP_ODD:  res_o[k*LANE_W +: LANE_W] = UHI  ? lb[UE + 1]   : la[UE + 1];
        M_ZIP_LO:   res_o[k*LANE_W +: LANE_W] = ODDK ? lb[ZL]       : la[ZL];
        M_ZIP_HI:   res_o[k*LANE_W +: LANE_W] = ODDK ? lb[ZH]       : la[ZH];
        default:    res_o[k*LANE_W +: LANE_W] = '0;
      endcase
    end
  end
endmodule

// File: rtl/vperm_extract.sv
module vperm_extract #(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned BYTES = VEC_W / 8,
  localparam int unsigned OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0] imm_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] res_o
);
  logic [7:0] cb [2*BYTES];

  for (genvar j = 0; j < BYTES; j++) begin : g_cat
    assign cb[j]         = a_i[j*8 +: 8];
    assign cb[BYTES + j] = b_i[j*8 +: 8];
  end

  for (genvar j = 0; j < BYTES; j++) begin : g_win
    assign res_o[j*8 +: 8] = cb[(OFF_W+1)'(imm_i) + (OFF_W+1)'(j)];
  end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import vperm_pkg::*;
#(
  parameter int unsigned VEC_W   = 128,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned OFF_W  = $clog2(VEC_W / 8)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       size_i,
  input  logic [OFF_W-1:0] imm_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] result_o,
  output logic             illegal_o
);
  vperm_mode_e      mode;
  logic [VEC_W-1:0] lane_res [NUM_SIZES];
  logic [VEC_W-1:0] ext_res;
  logic [VEC_W-1:0] comb_res;
  logic             comb_ill;

  assign mode = vperm_mode_e'(mode_i);

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    vperm_lanes #(.VEC_W(VEC_W), .LANE_W(MIN_LANE_W << g)) u_lanes (
      .mode_i(mode),
      .a_i   (src_a_i),
      .b_i   (src_b_i),
      .res_o (lane_res[g])
    );
  end

  vperm_extract #(.VEC_W(VEC_W)) u_ext (
    .imm_i(imm_i),
    .a_i  (src_a_i),
    .b_i  (src_b_i),
    .res_o(ext_res)
  );

  always_comb begin
    comb_ill = 1'b0;
    case (mode)
      M_EXTRACT: comb_res = ext_res;
      M_ILLEGAL: begin
        comb_res = '0;
        comb_ill = 1'b1;
      end
      default:   comb_res = lane_res[size_i];
    endcase
  end

  if (REG_OUT) begin : g_reg
    logic             valid_q;
    logic             ill_q;
    logic [VEC_W-1:0] res_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        ill_q   <= 1'b0;
        res_q   <= '0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) begin
          ill_q <= comb_ill;
          res_q <= comb_res;
        end
      end
    end

    assign valid_o   = valid_q;
    assign result_o  = res_q;
    assign illegal_o = valid_q & ill_q;

    p_valid_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    p_valid_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(result_o));
    p_illegal_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && mode_i == 3'd7) |=> illegal_o);
    p_ext_ident_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && mode_i == 3'd6 && imm_i == '0) |=> result_o == $past(src_a_i));
  end else begin : g_comb
    assign valid_o   = valid_i;
    assign result_o  = comb_res;
    assign illegal_o = valid_i & comb_ill;
  end

  p_illegal_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> result_o == '0);
endmodule

// File: tb/vperm_unit_test.sv
module vperm_unit_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   mode_i = '0;
  logic [1:0]   size_i = '0;
  logic [3:0]   imm_i = '0;
  logic [127:0] src_a_i = '0;
  logic [127:0] src_b_i = '0;
  logic         valid_o;
  logic [127:0] result_o;
  logic         illegal_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  vperm_unit uut (
    .clk_i, .rst_ni, .valid_i, .mode_i, .size_i, .imm_i,
    .src_a_i, .src_b_i, .valid_o, .result_o, .illegal_o
  );

  function automatic logic [127:0] pack4(input logic [31:0] x0, x1, x2, x3);
    return {x3, x2, x1, x0};
  endfunction

  function automatic logic [127:0] model(input int m, input int sz, input int imm,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    logic [255:0] cat = {b, a};
    int lw = 8 << sz;
    int n = 128 / lw;
    int src_idx;
    bit from_b;
    if (m == 6) begin
      for (int j = 0; j < 16; j++) r[j*8 +: 8] = cat[(imm + j)*8 +: 8];
      return r;
    end
    if (m == 7) return '0;
    for (int k = 0; k < n; k++) begin
      case (m)
        0: begin from_b = (k % 2) == 1; src_idx = k - (k % 2); end
        1: begin from_b = (k % 2) == 1; src_idx = k - (k % 2) + 1; end
        2: begin from_b = k >= n / 2; src_idx = 2 * (k % (n / 2)); end
        3: begin from_b = k >= n / 2; src_idx = 2 * (k % (n / 2)) + 1; end
        4: begin from_b = (k % 2) == 1; src_idx = k / 2; end
        default: begin from_b = (k % 2) == 1; src_idx = n / 2 + k / 2; end
      endcase
      for (int t = 0; t < lw; t++)
        r[k*lw + t] = from_b ? b[src_idx*lw + t] : a[src_idx*lw + t];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input int m, input int sz, input int imm,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk_i);
    valid_i = 1'b1; mode_i = 3'(m); size_i = 2'(sz); imm_i = 4'(imm);
    src_a_i = a; src_b_i = b;
    @(negedge clk_i);
  endtask

  function automatic string tag_of(input int m);
    case (m)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5: return "R3";
      6: return "R4";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] va, vb, hold;
    void'($urandom(32'h5eed_1234));
    va = pack4("A", "B", "C", "D");
    vb = pack4("E", "F", "G", "H");
    repeat (3) @(negedge clk_i);
    chk("R8 reset valid_o", 128'(valid_o), 128'(0));
    chk("R8 reset result", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 idle valid_o", 128'(valid_o), 128'(0));

    // directed character examples, 32-bit lanes
    apply(0, 2, 0, va, vb); chk("R1 trn even", result_o, pack4("A", "E", "C", "G"));
    chk("R8 valid_o after input", 128'(valid_o), 128'(1));
    apply(1, 2, 0, va, vb); chk("R1 trn odd", result_o, pack4("B", "F", "D", "H"));
    apply(2, 2, 0, va, vb); chk("R2 uzp even", result_o, pack4("A", "C", "E", "G"));
    apply(3, 2, 0, va, vb); chk("R2 uzp odd", result_o, pack4("B", "D", "F", "H"));
    apply(4, 2, 0, va, vb); chk("R3 zip lo", result_o, pack4("A", "E", "B", "F"));
    apply(5, 2, 0, va, vb); chk("R3 zip hi", result_o, pack4("C", "G", "D", "H"));
    apply(6, 2, 0, va, vb); chk("R5 ext 0", result_o, va);
    apply(6, 2, 4, va, vb); chk("R4 ext 4", result_o, pack4("B", "C", "D", "E"));
    apply(6, 2, 8, va, vb); chk("R4 ext 8", result_o, pack4("C", "D", "E", "F"));
    apply(6, 2, 12, va, vb); chk("R4 ext 12", result_o, pack4("D", "E", "F", "G"));
    apply(7, 2, 0, va, vb);
    chk("R7 illegal result", result_o, '0);
    chk("R7 illegal flag", 128'(illegal_o), 128'(1));

    // extract ignores size, every offset
    for (int off = 0; off < 16; off++) begin
      va = {$urandom, $urandom, $urandom, $urandom};
      vb = {$urandom, $urandom, $urandom, $urandom};
      for (int sz = 0; sz < 4; sz++) begin
        apply(6, sz, off, va, vb);
        chk("R6 R4 extract size ignored", result_o, model(6, 0, off, va, vb));
      end
    end

    // every lane mode at every size
    for (int sz = 0; sz < 4; sz++) begin
      for (int m = 0; m < 6; m++) begin
        va = {$urandom, $urandom, $urandom, $urandom};
        vb = {$urandom, $urandom, $urandom, $urandom};
        apply(m, sz, 0, va, vb);
        chk({"R6 ", tag_of(m), " lane size"}, result_o, model(m, sz, 0, va, vb));
      end
    end

    // hold while idle
    hold = result_o;
    valid_i = 1'b0;
    src_a_i = ~src_a_i; mode_i = 3'd6;
    @(negedge clk_i);
    chk("R8 valid drop", 128'(valid_o), 128'(0));
    @(negedge clk_i);
    chk("R9 hold result", result_o, hold);
    chk("R7 no flag when idle", 128'(illegal_o), 128'(0));

    // constrained random
    for (int i = 0; i < 400; i++) begin
      int m, sz, off;
      m = int'($urandom % 8); sz = int'($urandom % 4); off = int'($urandom % 16);
      va = {$urandom, $urandom, $urandom, $urandom};
      vb = {$urandom, $urandom, $urandom, $urandom};
      apply(m, sz, off, va, vb);
      chk({tag_of(m), " random"}, result_o, model(m, sz, off, va, vb));
      chk("R7 random flag", 128'(illegal_o), 128'(m == 7));
      if ((i % 7) == 3) begin
        valid_i = 1'b0;
        @(negedge clk_i);
        chk("R8 random gap", 128'(valid_o), 128'(0));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule